// File: doc/BRIEF.md
# Block-Boundary Access Splitter

This block sits between a load/store unit and a data-cache port that uses a valid/ready handshake. It accepts one load or store at a time, with a start address, a size code and, for stores, the write data. When the bytes of the access all fall inside one cache block, the access goes to the cache as a single fragment. When they straddle a block boundary, the block cuts the access into two fragments at that boundary and offers them in order. A fragment that the cache refuses is held unchanged until the cache takes it.

Each cache response carries a one-bit fragment index. Read bytes are written into a merged buffer at the lane that index implies, so responses may return in either order. The block raises a one-cycle completion pulse with the merged read data once every fragment has answered. Two kinds of access cannot be split, and the block completes them with an error flag and sends nothing to the cache: an atomic (locked, conditional or swap) access that would cross a boundary, and an access whose bytes touch more than two blocks.

Top module: `split_access_top`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after it is taken.
- R2: The size field value k means 2^k bytes (0..3 gives 1, 2, 4 or 8 bytes). An access whose first and last byte lie in the same block is offered as one fragment with index 0, the start address and the full byte count, and it completes after its single response.
- R3: An access whose last byte lies in the next block is split at the block-aligned address B of its last byte. Fragment 0 has index 0, the start address and B minus start bytes. Fragment 1 has index 1, address B and the rest of the bytes.
- R4: While the cache holds `frag_ready` low, the offered fragment keeps its address, byte count, index and write data unchanged.
- R5: Fragment 1 is first offered in the cycle after fragment 0 is accepted, and never earlier.
- R6: `done_valid` is a one-cycle pulse that rises only after every issued fragment has received a response.
- R7: Byte lane i is bits 8i+7..8i. In the completed read data, lanes 0..n0-1 hold lanes 0..n0-1 of the index-0 response, and lanes n0 onward hold the index-1 response starting from its lane 0, where n0 is the fragment 0 byte count. Responses may arrive in either index order. Lanes at and above the access size read as zero.
- R8: A store fragment carries its own bytes of the write data starting at lane 0. Fragment 0 takes write bytes 0..n0-1 and fragment 1 takes bytes n0 onward. All other lanes are zero.
- R9: An atomic access that would need splitting sends no fragment and completes with `done_err` high.
- R10: An access whose bytes touch more than two blocks sends no fragment and completes with `done_err` high.
- R11: An atomic access that stays inside one block is issued and completes normally, with `done_err` low.
- R12: An error completion has `done_valid` high in the cycle right after the request was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Load/store request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_atomic | input | 1 | Locked, conditional or swap access |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | SZC_W | Size code, 2^k bytes |
| req_wdata | input | 8*MAX_ACC_BYTES | Store data, byte 0 in lane 0 |
| frag_valid | output | 1 | Fragment offered to the cache |
| frag_ready | input | 1 | Cache accepts the offered fragment |
| frag_write | output | 1 | Fragment is a store |
| frag_addr | output | ADDR_W | Fragment start address |
| frag_nbytes | output | CNT_W | Fragment byte count |
| frag_idx | output | 1 | Fragment index, 0 or 1 |
| frag_wdata | output | 8*MAX_ACC_BYTES | Fragment store bytes from lane 0 |
| resp_valid | input | 1 | Cache response for one fragment |
| resp_idx | input | 1 | Index of the answered fragment |
| resp_rdata | input | 8*MAX_ACC_BYTES | Read bytes of that fragment from lane 0 |
| done_valid | output | 1 | Access complete, one-cycle pulse |
| done_err | output | 1 | Access rejected, nothing issued |
| done_rdata | output | 8*MAX_ACC_BYTES | Merged read data |

## Verification
The hardest situation to reach is a response for fragment 0 that arrives while fragment 1 is still held back by a refusing cache, together with the reversed case where fragment 1 answers first. The bench's cache model refuses each fragment index for a set number of cycles and answers each fragment as soon as it is accepted. This makes the fragment 0 reply land while fragment 1 is still waiting. In a second mode the model holds all replies of an access and returns them in reverse index order. A narrow 4-byte block is used so that two-block splits and three-block rejections both come from ordinary addresses.

// File: rtl/split_pkg.sv
package split_pkg;

   typedef enum logic [2:0] {
      SP_IDLE  = 3'd0,
      SP_SEND0 = 3'd1,
      SP_SEND1 = 3'd2,
      SP_WAIT  = 3'd3,
      SP_DONE  = 3'd4
   } sp_state_e;

   function automatic bit sp_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/split_calc.sv
// Combinational geometry of one request: fragment sizes, second address, legality.
module split_calc #(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_BYTES = 16,
   parameter int MAX_BYTES   = 8,
   parameter int SZC_W       = 2,
   parameter int CNT_W       = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SZC_W-1:0]  size_code,
   input  logic              atomic,
   output logic [ADDR_W-1:0] addr1,
   output logic [CNT_W-1:0]  n0,
   output logic [CNT_W-1:0]  n1,
   output logic              split,
   output logic              err
);
   localparam int BLK_LG = $clog2(BLOCK_BYTES);
   localparam int MAX_LG = $clog2(MAX_BYTES);
   localparam int BN_W   = ADDR_W - BLK_LG;
   localparam int OW     = (BLK_LG + 1 > CNT_W) ? BLK_LG + 1 : CNT_W;

   logic [CNT_W-1:0]  nbytes;
   logic [ADDR_W-1:0] last_a;
   logic [BN_W-1:0]   blk_a;
   logic [BN_W-1:0]   blk_l;
   logic [OW-1:0]     room;
   logic              size_bad;
   logic              span3;

   always_comb begin
      size_bad = (int'(size_code) > MAX_LG);
      nbytes   = size_bad ? CNT_W'(1) : (CNT_W'(1) << size_code);
      last_a   = addr + ADDR_W'(nbytes) - ADDR_W'(1);
      blk_a    = BN_W'(addr >> BLK_LG);
      blk_l    = BN_W'(last_a >> BLK_LG);
      split    = (blk_l != blk_a);
      addr1    = {blk_l, {BLK_LG{1'b0}}};
      room     = OW'(BLOCK_BYTES) - OW'(addr[BLK_LG-1:0]);
      n0       = split ? CNT_W'(room) : nbytes;
      n1       = split ? (nbytes - n0) : '0;
   end

   // A span of three blocks exists only when the block is smaller than the widest access.
   if (BLOCK_BYTES >= MAX_BYTES) begin : g_wide_blk
      assign span3 = 1'b0;
   end else begin : g_narrow_blk
      logic [BN_W-1:0] blk_d;
      assign blk_d = blk_l - blk_a;
      assign span3 = (blk_d > BN_W'(1));
   end

   assign err = span3 || (split && atomic) || size_bad;

endmodule

// File: rtl/split_seq.sv
// Issue sequencer: captures the request, offers fragments in order, counts responses.
module split_seq import split_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 4,
   parameter int DW     = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DW-1:0]     req_wdata,
   input  logic [ADDR_W-1:0] g_addr1,
   input  logic [CNT_W-1:0]  g_n0,
   input  logic [CNT_W-1:0]  g_n1,
   input  logic              g_split,
   input  logic              g_err,
   input  logic              c_ready,
   input  logic              r_valid,
   output logic              busy,
   output logic              c_valid,
   output logic              c_write,
   output logic [ADDR_W-1:0] c_addr,
   output logic [CNT_W-1:0]  c_nbytes,
   output logic              c_idx,
   output logic [DW-1:0]     c_wdata,
   output logic              done_valid,
   output logic              done_err,
   output logic [CNT_W-1:0]  geo_n0,
   output logic [CNT_W-1:0]  geo_n1
);
   localparam int NB = DW / 8;

   sp_state_e         st_q;
   logic [1:0]        cnt_q;
   logic [ADDR_W-1:0] a0_q, a1_q;
   logic [CNT_W-1:0]  n0_q, n1_q;
   logic              split_q, wr_q, err_q;
   logic [DW-1:0]     wbuf_q;
   logic [DW-1:0]     src;
   logic [CNT_W-1:0]  cur_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SP_IDLE;
         cnt_q   <= 2'd0;
         a0_q    <= '0;
         a1_q    <= '0;
         n0_q    <= '0;
         n1_q    <= '0;
         split_q <= 1'b0;
         wr_q    <= 1'b0;
         err_q   <= 1'b0;
         wbuf_q  <= '0;
      end else begin
         case (st_q)
            SP_IDLE: if (acc) begin
               a0_q    <= req_addr;
               a1_q    <= g_addr1;
               n0_q    <= g_n0;
               n1_q    <= g_n1;
               split_q <= g_split;
               wr_q    <= req_write;
               wbuf_q  <= req_wdata;
               err_q   <= g_err;
               st_q    <= g_err ? SP_DONE : SP_SEND0;
            end
            SP_SEND0: if (c_ready) st_q <= split_q ? SP_SEND1 : SP_WAIT;
            SP_SEND1: if (c_ready) st_q <= SP_WAIT;
            SP_WAIT:  if (cnt_q == 2'd0) st_q <= SP_DONE;
            SP_DONE:  st_q <= SP_IDLE;
            default:  st_q <= SP_IDLE;
         endcase
         if (st_q == SP_IDLE && acc)
            cnt_q <= g_err ? 2'd0 : (g_split ? 2'd2 : 2'd1);
         else if (r_valid && cnt_q != 2'd0)
            cnt_q <= cnt_q - 2'd1;
      end
   end

   always_comb begin
      cur_n = (st_q == SP_SEND1) ? n1_q : n0_q;
      src   = (st_q == SP_SEND1) ? (wbuf_q >> (8 * n0_q)) : wbuf_q;
   end

   for (genvar i = 0; i < NB; i++) begin : g_wlane
      assign c_wdata[8*i +: 8] = (CNT_W'(i) < cur_n) ? src[8*i +: 8] : 8'h00;
   end

   assign busy       = (st_q != SP_IDLE);
   assign c_valid    = (st_q == SP_SEND0) || (st_q == SP_SEND1);
   assign c_idx      = (st_q == SP_SEND1);
   assign c_addr     = (st_q == SP_SEND1) ? a1_q : a0_q;
   assign c_nbytes   = cur_n;
   assign c_write    = wr_q;
   assign done_valid = (st_q == SP_DONE);
   assign done_err   = err_q && (st_q == SP_DONE);
   assign geo_n0     = n0_q;
   assign geo_n1     = n1_q;

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (c_valid && !c_ready) |=> (c_valid && $stable(c_addr) && $stable(c_idx)
                                 && $stable(c_nbytes) && $stable(c_wdata)))
      else $error("R4: refused fragment changed");

   p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_valid && c_idx && !$past(c_valid && c_idx)) |-> $past(c_valid && !c_idx && c_ready))
      else $error("R5: fragment 1 offered before fragment 0 was taken");

   p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid)
      else $error("R6: completion longer than one cycle");

   p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_err) |-> $past(cnt_q == 2'd0))
      else $error("R6: completion with responses still owed");

endmodule

// File: rtl/split_merge.sv
// Read reassembly: places each response's bytes at the lanes its index selects.
module split_merge #(
   parameter int DW    = 64,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             r_valid,
   input  logic             r_idx,
   input  logic [DW-1:0]    r_rdata,
   input  logic [CNT_W-1:0] n0,
   input  logic [CNT_W-1:0] n1,
   output logic [DW-1:0]    merged
);
   localparam int NB = DW / 8;

   logic [DW-1:0] shifted;
   assign shifted = r_rdata << (8 * n0);

   for (genvar i = 0; i < NB; i++) begin : g_lane
      logic       hit0, hit1;
      logic [7:0] lane_q;
      assign hit0 = r_valid && !r_idx && (CNT_W'(i) < n0);
      assign hit1 = r_valid &&  r_idx && (CNT_W'(i) >= n0) && (CNT_W'(i) < (n0 + n1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    lane_q <= 8'h00;
         else if (clr)  lane_q <= 8'h00;
         else if (hit0) lane_q <= r_rdata[8*i +: 8];
         else if (hit1) lane_q <= shifted[8*i +: 8];
      end
      assign merged[8*i +: 8] = lane_q;
   end

endmodule

// File: rtl/split_access_top.sv
module split_access_top import split_pkg::*; #(
   parameter int ADDR_W        = 32,
   parameter int BLOCK_BYTES   = 16,
   parameter int MAX_ACC_BYTES = 8,
   localparam int DW    = 8 * MAX_ACC_BYTES,
   localparam int SZC_W = $clog2($clog2(MAX_ACC_BYTES) + 1),
   localparam int CNT_W = $clog2(MAX_ACC_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_atomic,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SZC_W-1:0]  req_size,
   input  logic [DW-1:0]     req_wdata,
   output logic              frag_valid,
   input  logic              frag_ready,
   output logic              frag_write,
   output logic [ADDR_W-1:0] frag_addr,
   output logic [CNT_W-1:0]  frag_nbytes,
   output logic              frag_idx,
   output logic [DW-1:0]     frag_wdata,
   input  logic              resp_valid,
   input  logic              resp_idx,
   input  logic [DW-1:0]     resp_rdata,
   output logic              done_valid,
   output logic              done_err,
   output logic [DW-1:0]     done_rdata
);
   if (!sp_pow2(BLOCK_BYTES) || BLOCK_BYTES < 2) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two, at least 2");
   end
   if (!sp_pow2(MAX_ACC_BYTES) || MAX_ACC_BYTES < 2) begin : g_bad_width
      $error("MAX_ACC_BYTES must be a power of two, at least 2");
   end
   if (ADDR_W <= $clog2(BLOCK_BYTES)) begin : g_bad_addr
      $error("ADDR_W must exceed the block offset width");
   end

   logic              busy, acc;
   logic [ADDR_W-1:0] g_addr1;
   logic [CNT_W-1:0]  g_n0, g_n1, geo_n0, geo_n1;
   logic              g_split, g_err;

   assign req_ready = !busy;
   assign acc       = req_valid && !busy;

   split_calc #(
      .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .MAX_BYTES(MAX_ACC_BYTES),
      .SZC_W(SZC_W), .CNT_W(CNT_W)
   ) u_calc (
      .addr(req_addr), .size_code(req_size), .atomic(req_atomic),
      .addr1(g_addr1), .n0(g_n0), .n1(g_n1), .split(g_split), .err(g_err)
   );

   split_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .acc(acc),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .g_addr1(g_addr1), .g_n0(g_n0), .g_n1(g_n1), .g_split(g_split), .g_err(g_err),
      .c_ready(frag_ready), .r_valid(resp_valid),
      .busy(busy), .c_valid(frag_valid), .c_write(frag_write), .c_addr(frag_addr),
      .c_nbytes(frag_nbytes), .c_idx(frag_idx), .c_wdata(frag_wdata),
      .done_valid(done_valid), .done_err(done_err),
      .geo_n0(geo_n0), .geo_n1(geo_n1)
   );

   split_merge #(.DW(DW), .CNT_W(CNT_W)) u_merge (
      .clk(clk), .rst_n(rst_n), .clr(acc),
      .r_valid(resp_valid), .r_idx(resp_idx), .r_rdata(resp_rdata),
      .n0(geo_n0), .n1(geo_n1), .merged(done_rdata)
   );

   p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready)
      else $error("R1: still ready after taking a request");

   p_err_timing_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_err) |-> $past(req_valid && req_ready))
      else $error("R12: error completion not in the cycle after acceptance");

   p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && g_err) |=> !frag_valid)
      else $error("R9: fragment offered for a rejected access");

   p_resp_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !req_ready)
      else $error("R6: response while idle");

endmodule

// File: tb/tb_split_access_top.sv
module tb_split_access_top;
   localparam int AW = 32;
   localparam int BB = 4;
   localparam int MB = 8;
   localparam int DW = 64;
   localparam int CW = 4;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic          req_atomic = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_size = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          frag_valid;
   logic          frag_ready = 1'b0;
   logic          frag_write;
   logic [AW-1:0] frag_addr;
   logic [CW-1:0] frag_nbytes;
   logic          frag_idx;
   logic [DW-1:0] frag_wdata;
   logic          resp_valid = 1'b0;
   logic          resp_idx = 1'b0;
   logic [DW-1:0] resp_rdata = '0;
   logic          done_valid;
   logic          done_err;
   logic [DW-1:0] done_rdata;

   always #2.5 clk = ~clk;

   split_access_top #(.ADDR_W(AW), .BLOCK_BYTES(BB), .MAX_ACC_BYTES(MB)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_atomic(req_atomic), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata), .frag_valid(frag_valid),
      .frag_ready(frag_ready), .frag_write(frag_write), .frag_addr(frag_addr),
      .frag_nbytes(frag_nbytes), .frag_idx(frag_idx), .frag_wdata(frag_wdata),
      .resp_valid(resp_valid), .resp_idx(resp_idx), .resp_rdata(resp_rdata),
      .done_valid(done_valid), .done_err(done_err), .done_rdata(done_rdata)
   );

   typedef struct {logic [31:0] a; int n; bit idx; bit wr; logic [63:0] wd; string tag;} frag_t;
   typedef struct {bit err; bit wr; logic [63:0] rd; string tag;} done_t;
   typedef struct {logic [31:0] a; int n; bit idx;} rsp_t;

   frag_t fq[$];
   done_t dq[$];
   rsp_t  rq[$];
   rsp_t  hold[$];
   int    errs = 0;
   int    checks = 0;
   int    refuse0 = 0, refuse1 = 0, nfr_exp = 0;
   bit    swap_rsp = 1'b0;
   frag_t fe;
   done_t de;
   rsp_t  rcur;

   function automatic logic [7:0] memb(input logic [31:0] a);
      return 8'(a * 13 + 5);
   endfunction

   function automatic logic [63:0] keep(input logic [63:0] v, input int n);
      logic [63:0] r = '0;
      for (int i = 0; i < 8; i++) if (i < n) r[8*i +: 8] = v[8*i +: 8];
      return r;
   endfunction

   function automatic logic [63:0] rsp_data(input logic [31:0] a, input int n);
      logic [63:0] r = '0;
      for (int i = 0; i < 8; i++) r[8*i +: 8] = (i < n) ? memb(a + 32'(i)) : 8'hEE;
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Cache model and scoreboard monitor.
   always @(negedge clk) begin
      if (rst_n) begin
         if (rq.size() > 0) begin
            rcur       = rq.pop_front();
            resp_valid = 1'b1;
            resp_idx   = rcur.idx;
            resp_rdata = rsp_data(rcur.a, rcur.n);
         end else begin
            resp_valid = 1'b0;
         end
         frag_ready = 1'b0;
         if (frag_valid) begin
            if (fq.size() == 0) begin
               chk(1'b0, "R9/R10 unexpected fragment", 64'(frag_addr), 64'd0);
            end else begin
               fe = fq[0];
               if ((frag_idx ? refuse1 : refuse0) > 0) begin
                  if (frag_idx) refuse1--; else refuse0--;
                  chk(frag_addr == fe.a && frag_idx == fe.idx && int'(frag_nbytes) == fe.n
                      && (!fe.wr || frag_wdata == fe.wd),
                      "R4 refused fragment held", 64'(frag_addr), 64'(fe.a));
               end else begin
                  frag_ready = 1'b1;
                  void'(fq.pop_front());
                  chk(frag_addr == fe.a && frag_idx == fe.idx && int'(frag_nbytes) == fe.n
                      && frag_write == fe.wr,
                      fe.tag, {frag_addr, 27'd0, frag_nbytes, frag_idx},
                      {fe.a, 27'd0, 4'(fe.n), fe.idx});
                  if (fe.wr) chk(frag_wdata == fe.wd, "R8 store slice", frag_wdata, fe.wd);
                  rcur.a = fe.a; rcur.n = fe.n; rcur.idx = fe.idx;
                  if (swap_rsp) begin
                     hold.push_front(rcur);
                     if (hold.size() == nfr_exp)
                        while (hold.size() > 0) rq.push_back(hold.pop_front());
                  end else begin
                     rq.push_back(rcur);
                  end
               end
            end
         end
         if (done_valid) begin
            if (dq.size() == 0) begin
               chk(1'b0, "R6 unexpected completion", 64'd1, 64'd0);
            end else begin
               de = dq.pop_front();
               chk(done_err == de.err, {de.tag, " error flag"}, 64'(done_err), 64'(de.err));
               if (!de.err) chk(rq.size() == 0 && hold.size() == 0 && fq.size() == 0,
                                "R6 completion before all responses", 64'(rq.size()), 64'd0);
               if (!de.err && !de.wr)
                  chk(done_rdata == de.rd, {de.tag, " merged data"}, done_rdata, de.rd);
            end
         end
      end
   end

   task automatic run_acc(input string tag, input bit wr, input bit at, input logic [31:0] a,
                          input int sz, input logic [63:0] wd,
                          input int rf0 = 0, input int rf1 = 0, input bit sw = 1'b0);
      int          nb = 1 << sz;
      logic [31:0] last = a + 32'(nb) - 32'd1;
      logic [31:0] bd = (last / BB) - (a / BB);
      bit          split = (bd != 0);
      bit          err = (bd > 1) || (split && at);
      logic [31:0] a1 = (last / BB) * BB;
      int          n0 = split ? int'(a1 - a) : nb;
      frag_t       f;
      done_t       d;
      d.err = err; d.wr = wr; d.tag = tag; d.rd = '0;
      for (int i = 0; i < nb; i++) d.rd[8*i +: 8] = memb(a + 32'(i));
      nfr_exp = err ? 0 : (split ? 2 : 1);
      if (!err) begin
         f.a = a; f.n = n0; f.idx = 1'b0; f.wr = wr; f.wd = keep(wd, n0);
         f.tag = split ? "R3 fragment 0 geometry" : "R2 single fragment";
         fq.push_back(f);
         if (split) begin
            f.a = a1; f.n = nb - n0; f.idx = 1'b1; f.wd = keep(wd >> (8 * n0), nb - n0);
            f.tag = "R3/R5 fragment 1 geometry";
            fq.push_back(f);
         end
      end
      dq.push_back(d);
      refuse0 = rf0; refuse1 = rf1; swap_rsp = sw;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready while idle", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_write = wr; req_atomic = at; req_addr = a;
      req_size = SW'(sz); req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R1 ready low after accept", 64'(req_ready), 64'd0);
      if (err) chk(done_valid && done_err, "R12 error completion timing",
                   64'({done_valid, done_err}), 64'd3);
      while (dq.size() != 0) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++; checks++;
      $display("FAIL R6 watchdog act=no completion exp=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(req_ready == 1'b1 && frag_valid == 1'b0 && done_valid == 1'b0,
          "R1 reset state", 64'({req_ready, frag_valid, done_valid}), 64'h4);
      rst_n = 1'b1;
      @(negedge clk);
      run_acc("R2 aligned word read", 0, 0, 32'h100, 2, 64'h0);
      run_acc("R2 byte read", 0, 0, 32'h103, 0, 64'h0);
      run_acc("R3/R7 split word read", 0, 0, 32'h102, 2, 64'h0);
      run_acc("R3/R7 split double read", 0, 0, 32'h200, 3, 64'h0);
      run_acc("R10 three block read", 0, 0, 32'h201, 3, 64'h0);
      run_acc("R10 three block store", 1, 0, 32'h202, 3, 64'h1122334455667788);
      run_acc("R3/R7 split half read", 0, 0, 32'h203, 1, 64'h0);
      run_acc("R8 split word store", 1, 0, 32'h305, 2, 64'hA1A2A3A4_B1B2B3B4);
      run_acc("R4/R8 refused split store", 1, 0, 32'h304, 3, 64'h0102030405060708, 3, 0);
      run_acc("R4/R6 early response read", 0, 0, 32'h311, 2, 64'h0, 0, 3);
      run_acc("R7 reversed responses", 0, 0, 32'h322, 2, 64'h0, 0, 0, 1);
      run_acc("R7 reversed refused", 0, 0, 32'h334, 3, 64'h0, 2, 2, 1);
      run_acc("R9 atomic split", 0, 1, 32'h102, 2, 64'h0);
      run_acc("R9 atomic split store", 1, 1, 32'h107, 1, 64'hFFFF);
      run_acc("R11 atomic inside block", 0, 1, 32'h104, 2, 64'h0);
      run_acc("R11/R8 atomic store inside block", 1, 1, 32'h10A, 1, 64'hDEAD_BEEF_CAFE_F00D);
      run_acc("R8 single half store", 1, 0, 32'h10, 1, 64'h9988_7766_5544_3322);
      for (int a = 0; a < 8; a++)
         for (int s = 0; s < 4; s++)
            run_acc("R2/R3/R7/R10 sweep read", 0, 0, 32'h400 + 32'(a), s, 64'h0, a % 2, s % 2, (a + s) % 3 == 0);
      chk(fq.size() == 0 && dq.size() == 0, "R6 scoreboard drained", 64'(fq.size() + dq.size()), 64'd0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule